// File: doc/BRIEF.md
# SMRAM Legacy Window Router

This block keeps the one-byte control register that decides who answers accesses to the 128 KB legacy graphics window (byte addresses 0xA0000 up to but not including 0xC0000). The register sits at one byte offset of a host bridge configuration space and is reached through a byte-wide configuration port. For every access request the block returns a routing decision, either to system DRAM (where the system-management code and data live) or to the PCI/VGA side.

The window is visible as DRAM only when the global enable bit is set and either software has opened it or the processor reports that it is in system-management mode. The mode input is live: a change takes effect on the next access with no configuration traffic. A lock bit, once written to 1, closes the window for normal code and freezes the enable, open and lock bits until the next reset.

Top module: `smram_window_ctrl`

## Requirements
- R1: After reset the register reads 0x02 and every in-window access is routed to the PCI side, whatever the mode input.
- R2: Bits 2:0 always read as binary 010 and bit 7 always reads 0, whatever value was written.
- R3: A write with the address equal to 0x9D changes the value read back from the following cycle on; writes to any other offset leave it unchanged, and reads of any other offset return 0x00.
- R4: An in-window access presented at a clock edge gives a one-cycle route pulse at the next edge, to DRAM if bit 3 (global enable) is 1 and either bit 6 (open) or the mode input is 1, and to the PCI side otherwise.
- R5: Addresses 0xA0000 and 0xBFFFF are in the window; 0x9FFFF and 0xC0000 produce no route pulse.
- R6: Raising or lowering the mode input alone changes the route of the next access.
- R7: A write with bit 4 (lock) set stores open as 0 regardless of bit 6; while locked, writes change only bit 5 (close), and open, lock and global enable keep their values.
- R8: The lock holds until reset; after reset the register is writable again.
- R9: While the route pulse is high exactly one of the DRAM and PCI outputs is high; while it is low both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgRdEn | input | 1 | Configuration byte read strobe |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read data, combinational, 0 unless the read hits the register |
| smmActive | input | 1 | Processor is in system-management mode |
| accValid | input | 1 | Memory access request |
| accAddr | input | 32 | Memory access byte address |
| accWrite | input | 1 | Access is a write |
| routeValid | output | 1 | Registered pulse: the previous request hit the window |
| routeDram | output | 1 | Route the access to DRAM |
| routePci | output | 1 | Route the access to the PCI/VGA side |
| routeWrite | output | 1 | Direction of the routed access |

## Verification
Read data is combinational, so the bench samples it one time step after driving the read strobe in the same low clock phase. A register write lands at the rising edge after it is driven, and the route decision is registered, so an access driven before edge N shows its route between edge N and edge N+1; the bench drives on the falling edge and samples at the next falling edge. Expected routes are computed from a bench model of the register updated only after each write's edge, together with the mode level driven alongside the access, which is the value the design captures at that same edge.

// File: rtl/smram_win_pkg.sv
package smram_win_pkg;

  // Bit positions inside the control byte
  localparam int BIT_OPEN  = 6;
  localparam int BIT_CLOSE = 5;
  localparam int BIT_LOCK  = 4;
  localparam int BIT_GEN   = 3;

  // Strobes from the register control to the routing datapath
  typedef struct packed {
    logic globalEn;
    logic openWin;
    logic closeWin;
    logic locked;
  } winCtrl_t;

endpackage

// File: rtl/smram_cfg_reg.sv
module smram_cfg_reg
  import smram_win_pkg::*;
#(
  parameter int            CFG_ADDR_W = 8,
  parameter logic [7:0]    REG_OFFSET = 8'h9D,
  parameter logic [2:0]    SEG_CODE   = 3'b010
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic                  cfgRdEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [7:0]            cfgWrData,
  output logic [7:0]            cfgRdData,
  output winCtrl_t              ctrlStb
);

  localparam logic [CFG_ADDR_W-1:0] HIT_ADDR = CFG_ADDR_W'(REG_OFFSET);

  logic openQ, closeQ, lockQ, genQ;
  logic regHit, wrHit;

  assign regHit = (cfgAddr == HIT_ADDR);
  assign wrHit  = cfgWrEn & regHit;

  // Writable fields; lock freezes open, lock and enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openQ  <= 1'b0;
      closeQ <= 1'b0;
      lockQ  <= 1'b0;
      genQ   <= 1'b0;
    end else if (wrHit) begin
      closeQ <= cfgWrData[BIT_CLOSE];
      if (!lockQ) begin
        lockQ <= cfgWrData[BIT_LOCK];
        genQ  <= cfgWrData[BIT_GEN];
        openQ <= cfgWrData[BIT_OPEN] & ~cfgWrData[BIT_LOCK];
      end
    end
  end

  always_comb begin
    cfgRdData = 8'h00;
    if (cfgRdEn && regHit) begin
      cfgRdData[2:0]       = SEG_CODE;
      cfgRdData[BIT_GEN]   = genQ;
      cfgRdData[BIT_LOCK]  = lockQ;
      cfgRdData[BIT_CLOSE] = closeQ;
      cfgRdData[BIT_OPEN]  = openQ;
    end
  end

  assign ctrlStb.globalEn = genQ;
  assign ctrlStb.openWin  = openQ;
  assign ctrlStb.closeWin = closeQ;
  assign ctrlStb.locked   = lockQ;

endmodule

// File: rtl/smram_route_path.sv
module smram_route_path
  import smram_win_pkg::*;
#(
  parameter int          ACC_ADDR_W = 32,
  parameter logic [31:0] WIN_BASE   = 32'h000A_0000,
  parameter logic [31:0] WIN_SIZE   = 32'h0002_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  winCtrl_t              ctrlStb,
  input  logic                  smmActive,
  input  logic                  accValid,
  input  logic [ACC_ADDR_W-1:0] accAddr,
  input  logic                  accWrite,
  output logic                  routeValid,
  output logic                  routeDram,
  output logic                  routePci,
  output logic                  routeWrite
);

  localparam logic [ACC_ADDR_W:0] LO_BOUND = (ACC_ADDR_W+1)'(WIN_BASE);
  localparam logic [ACC_ADDR_W:0] HI_BOUND = (ACC_ADDR_W+1)'(WIN_BASE) + (ACC_ADDR_W+1)'(WIN_SIZE);

  logic [ACC_ADDR_W:0] addrExt;
  logic inWindow, visible, hit;

  assign addrExt  = {1'b0, accAddr};
  assign inWindow = (addrExt >= LO_BOUND) && (addrExt < HI_BOUND);
  assign hit      = accValid & inWindow;
  // Live mode input joins the stored bits at the decision edge
  assign visible  = ctrlStb.globalEn & (ctrlStb.openWin | smmActive);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeValid <= 1'b0;
      routeDram  <= 1'b0;
      routePci   <= 1'b0;
      routeWrite <= 1'b0;
    end else begin
      routeValid <= hit;
      routeDram  <= hit & visible;
      routePci   <= hit & ~visible;
      routeWrite <= hit & accWrite;
    end
  end

endmodule

// File: rtl/smram_window_ctrl.sv
module smram_window_ctrl
  import smram_win_pkg::*;
#(
  parameter int          CFG_ADDR_W = 8,
  parameter int          ACC_ADDR_W = 32,
  parameter logic [7:0]  REG_OFFSET = 8'h9D,
  parameter logic [2:0]  SEG_CODE   = 3'b010,
  parameter logic [31:0] WIN_BASE   = 32'h000A_0000,
  parameter logic [31:0] WIN_SIZE   = 32'h0002_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic                  cfgRdEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [7:0]            cfgWrData,
  output logic [7:0]            cfgRdData,
  input  logic                  smmActive,
  input  logic                  accValid,
  input  logic [ACC_ADDR_W-1:0] accAddr,
  input  logic                  accWrite,
  output logic                  routeValid,
  output logic                  routeDram,
  output logic                  routePci,
  output logic                  routeWrite
);

  winCtrl_t ctrlStb;
  logic stbGlobalEn, stbOpen, stbLocked;

  assign stbGlobalEn = ctrlStb.globalEn;
  assign stbOpen     = ctrlStb.openWin;
  assign stbLocked   = ctrlStb.locked;

  smram_cfg_reg #(
    .CFG_ADDR_W(CFG_ADDR_W),
    .REG_OFFSET(REG_OFFSET),
    .SEG_CODE  (SEG_CODE)
  ) u_cfg (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgRdEn  (cfgRdEn),
    .cfgAddr  (cfgAddr),
    .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .ctrlStb  (ctrlStb)
  );

  smram_route_path #(
    .ACC_ADDR_W(ACC_ADDR_W),
    .WIN_BASE  (WIN_BASE),
    .WIN_SIZE  (WIN_SIZE)
  ) u_route (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlStb   (ctrlStb),
    .smmActive (smmActive),
    .accValid  (accValid),
    .accAddr   (accAddr),
    .accWrite  (accWrite),
    .routeValid(routeValid),
    .routeDram (routeDram),
    .routePci  (routePci),
    .routeWrite(routeWrite)
  );

endmodule

// File: rtl/smram_window_checker.sv
module smram_window_checker #(
  parameter int          CFG_ADDR_W = 8,
  parameter int          ACC_ADDR_W = 32,
  parameter logic [7:0]  REG_OFFSET = 8'h9D,
  parameter logic [2:0]  SEG_CODE   = 3'b010,
  parameter logic [31:0] WIN_BASE   = 32'h000A_0000,
  parameter logic [31:0] WIN_SIZE   = 32'h0002_0000
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cfgRdEn,
  input logic [CFG_ADDR_W-1:0] cfgAddr,
  input logic [7:0]            cfgRdData,
  input logic                  smmActive,
  input logic                  accValid,
  input logic [ACC_ADDR_W-1:0] accAddr,
  input logic                  routeValid,
  input logic                  routeDram,
  input logic                  routePci,
  input logic                  stbGlobalEn,
  input logic                  stbOpen,
  input logic                  stbLocked
);

  localparam logic [ACC_ADDR_W:0] LO_B = (ACC_ADDR_W+1)'(WIN_BASE);
  localparam logic [ACC_ADDR_W:0] HI_B = (ACC_ADDR_W+1)'(WIN_BASE) + (ACC_ADDR_W+1)'(WIN_SIZE);

  logic outside;
  assign outside = ({1'b0, accAddr} < LO_B) || ({1'b0, accAddr} >= HI_B);

  assert_seg_field_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdEn && cfgAddr == CFG_ADDR_W'(REG_OFFSET)) |-> (cfgRdData[2:0] == SEG_CODE && !cfgRdData[7]));

  assert_route_rule_R4: assert property (@(posedge clk) disable iff (!rstN)
    routeValid |-> (routeDram == ($past(stbGlobalEn) & ($past(stbOpen) | $past(smmActive)))));

  assert_outside_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && outside) |=> !routeValid);

  assert_frozen_when_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(stbLocked) |-> ($stable(stbGlobalEn) && !stbOpen));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    stbLocked |=> stbLocked);

  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rstN)
    routeValid |-> $onehot({routeDram, routePci}));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !routeValid |-> (!routeDram && !routePci));

endmodule

bind smram_window_ctrl smram_window_checker #(
  .CFG_ADDR_W(CFG_ADDR_W),
  .ACC_ADDR_W(ACC_ADDR_W),
  .REG_OFFSET(REG_OFFSET),
  .SEG_CODE  (SEG_CODE),
  .WIN_BASE  (WIN_BASE),
  .WIN_SIZE  (WIN_SIZE)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgRdEn    (cfgRdEn),
  .cfgAddr    (cfgAddr),
  .cfgRdData  (cfgRdData),
  .smmActive  (smmActive),
  .accValid   (accValid),
  .accAddr    (accAddr),
  .routeValid (routeValid),
  .routeDram  (routeDram),
  .routePci   (routePci),
  .stbGlobalEn(stbGlobalEn),
  .stbOpen    (stbOpen),
  .stbLocked  (stbLocked)
);

// File: tb/sim_smram_window_ctrl.sv
`timescale 1ns/1ps
module sim_smram_window_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFF = 8'h9D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0, cfgRdEn = 1'b0;
  logic [7:0] cfgAddr = 8'h00, cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic smmActive = 1'b0;
  logic accValid = 1'b0, accWrite = 1'b0;
  logic [31:0] accAddr = 32'h0;
  logic routeValid, routeDram, routePci, routeWrite;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model of the register
  logic mOpen, mClose, mLock, mGen;

  always #(CLK_PERIOD/2) clk = ~clk;

  smram_window_ctrl u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .smmActive(smmActive), .accValid(accValid), .accAddr(accAddr),
    .accWrite(accWrite), .routeValid(routeValid), .routeDram(routeDram),
    .routePci(routePci), .routeWrite(routeWrite)
  );

  function automatic logic [7:0] modelByte();
    return {1'b0, mOpen, mClose, mLock, mGen, 3'b010};
  endfunction

  function automatic bit inWin(logic [31:0] a);
    return (a >= 32'hA0000) && (a < 32'hC0000);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mOpen = 0; mClose = 0; mLock = 0; mGen = 0;
  endtask

  task automatic cfgWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a == OFF) begin
      mClose = d[5];
      if (!mLock) begin
        mLock = d[4];
        mGen  = d[3];
        mOpen = d[6] & ~d[4];
      end
    end
  endtask

  task automatic cfgRead(logic [7:0] a, string req);
    logic [7:0] exp;
    @(negedge clk);
    cfgRdEn = 1'b1; cfgAddr = a;
    #1;
    exp = (a == OFF) ? modelByte() : 8'h00;
    check(cfgRdData == exp, req, {24'h0, cfgRdData}, {24'h0, exp});
    cfgRdEn = 1'b0;
  endtask

  task automatic access(logic [31:0] a, logic wr, logic smm, string req);
    logic expV, expD, expP;
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accWrite = wr; smmActive = smm;
    expV = inWin(a);
    expD = expV & mGen & (mOpen | smm);
    expP = expV & ~expD;
    @(negedge clk);
    check({routeValid, routeDram, routePci, routeWrite} == {expV, expD, expP, expV & wr},
          req, {28'h0, routeValid, routeDram, routePci, routeWrite},
          {28'h0, expV, expD, expP, expV & wr});
    check((routeDram ^ routePci) == routeValid, "R9",
          {30'h0, routeDram, routePci}, {31'h0, routeValid});
    accValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mOpen = 0; mClose = 0; mLock = 0; mGen = 0;
    doReset();

    // R1: reset state
    cfgRead(OFF, "R1");
    access(32'hA0000, 1'b0, 1'b1, "R1");
    access(32'hB0000, 1'b1, 1'b0, "R1");

    // R3: other offsets
    cfgWrite(8'h9E, 8'hFF);
    cfgWrite(8'h9C, 8'h48);
    cfgRead(OFF, "R3");
    cfgRead(8'h9E, "R3");

    // R4/R6: enable only, mode input selects
    cfgWrite(OFF, 8'h08);
    cfgRead(OFF, "R3");
    access(32'hA0000, 1'b0, 1'b0, "R6");
    access(32'hA0000, 1'b0, 1'b1, "R6");
    access(32'hA0000, 1'b1, 1'b0, "R6");

    // R4/R5: open window and boundaries
    cfgWrite(OFF, 8'h48);
    access(32'hA0000, 1'b1, 1'b0, "R4");
    access(32'h9FFFF, 1'b0, 1'b0, "R5");
    access(32'hBFFFF, 1'b0, 1'b0, "R5");
    access(32'hC0000, 1'b0, 1'b1, "R5");
    access(32'hFFFFFFFF, 1'b0, 1'b1, "R5");

    // R2: hardwired and reserved bits
    cfgWrite(OFF, 8'hA7);
    cfgRead(OFF, "R2");
    access(32'hA8000, 1'b0, 1'b1, "R4");

    // R7: lock clears open, then freezes
    cfgWrite(OFF, 8'h58);
    cfgRead(OFF, "R7");
    cfgWrite(OFF, 8'h60);
    cfgRead(OFF, "R7");
    cfgWrite(OFF, 8'h00);
    cfgRead(OFF, "R7");
    access(32'hA0000, 1'b0, 1'b0, "R7");
    access(32'hA0000, 1'b0, 1'b1, "R7");

    // R8: reset releases lock
    doReset();
    cfgRead(OFF, "R8");
    cfgWrite(OFF, 8'h48);
    cfgRead(OFF, "R8");
    access(32'hBFFF0, 1'b0, 1'b0, "R8");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] d;
      if (i % 100 == 99) doReset();
      op = $urandom % 10;
      d = 8'($urandom);
      if ($urandom % 8 != 0) d[4] = 1'b0;
      if (op < 3) cfgWrite(OFF, d);
      else if (op == 3) cfgWrite(8'($urandom), d);
      else if (op < 6) cfgRead(($urandom % 2 == 0) ? OFF : 8'($urandom), "R3");
      else access(32'h9FFF8 + ($urandom % 32'h20010), 1'($urandom), 1'($urandom), "R4");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule